// File: doc/BRIEF.md
# Byte FIFO Backed by External Page Memory

This block is a byte-wide first-in first-out queue whose storage lives in a region of an external memory rather than on chip. The external memory is reached through a request port that moves one whole page per transaction. On chip the block keeps only two page-sized register buffers. The staging buffer collects pushed bytes and is written out as a unit once its page is complete. The prefetch buffer holds the page the reader is currently consuming.

A producer pushes with a valid/ready pair and a consumer pops with a second valid/ready pair. The popped byte is shown on `pop_data` whenever `pop_ready` is high. When the reader and the writer sit in the same page, pops are served straight from the staging buffer, so short bursts never wait for the external memory. While a page write or page read is outstanding, both sides stall. A clear input empties the queue and reloads the first page of the region.

Top module: `ext_ram_fifo`

## Requirements
- R1: With parameter DEPTH the queue holds at most DEPTH bytes. `full` is high and pushes are refused while DEPTH bytes are stored. `empty` is high and pops are refused while nothing is stored. After reset the queue is empty.
- R2: Bytes leave in the order they entered, across page boundaries and across wraps of the DEPTH+1-slot ring.
- R3: When a push fills the last slot of a page (ring slots k*PAGE to k*PAGE+PAGE-1), or fills ring slot DEPTH, the block issues one write request (`mem_we`=1) carrying the whole staging page. The request goes to address BASE_ADDR + k*PAGE. `mem_wdata` byte i, bits [8i+7:8i], goes to address `mem_addr`+i.
- R4: When a pop moves the read slot to a multiple of PAGE, or wraps it to 0, the block issues a read request (`mem_we`=0) at BASE_ADDR plus the new slot number. Later pops from that page return the fetched bytes.
- R5: Bytes that are pushed and popped while the reader and the writer share a page are delivered without any write request.
- R6: While a request is outstanding, `push_ready` and `pop_ready` are low. `mem_req`, `mem_we` and `mem_addr` stay stable until the cycle in which `mem_ack` is high. The request is withdrawn after that cycle.
- R7: `used_cnt` equals the number of stored bytes, and `free_cnt` equals DEPTH minus `used_cnt`.
- R8: A clear accepted while no request is outstanding empties the queue and issues a read request at BASE_ADDR. Reset does the same. A clear presented while a request is outstanding has no effect.
- R9: Only one operation is accepted per cycle. Clear takes priority over pop, and pop takes priority over push. A push is refused in any cycle in which a pop of a non-empty queue is requested.
- R10: Every request address lies in [BASE_ADDR, BASE_ADDR + (ceil(DEPTH/PAGE)+1)*PAGE) at a page-multiple offset from BASE_ADDR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr | input | 1 | Empty the queue and reload page zero |
| push_valid | input | 1 | Producer offers a byte |
| push_data | input | 8 | Byte to push |
| push_ready | output | 1 | Push accepted this cycle if valid |
| pop_valid | input | 1 | Consumer takes a byte |
| pop_data | output | 8 | Head byte, valid while pop_ready |
| pop_ready | output | 1 | Pop accepted this cycle if valid |
| full | output | 1 | DEPTH bytes stored |
| empty | output | 1 | No byte stored |
| free_cnt | output | $clog2(DEPTH+1) | Free slots |
| used_cnt | output | $clog2(DEPTH+1) | Stored bytes |
| mem_req | output | 1 | External page request pending |
| mem_we | output | 1 | 1 for page write, 0 for page read |
| mem_addr | output | AW | Byte address of the page |
| mem_wdata | output | 8*PAGE | Page written, byte i at bits [8i+7:8i] |
| mem_ack | input | 1 | Request completes this cycle |
| mem_rdata | input | 8*PAGE | Page read, valid with mem_ack |

## Verification
The main function is driven by several input patterns. Pure fill-then-drain runs cover the full and empty limits and every page write and read in sequence. Short push/pop bursts inside one page separate the staging bypass from the page fetch path, because the external memory starts out holding a marker value that a wrong source would expose. Long mixed runs at several push/pop ratios cross the partial last page and the ring wrap many times in different alignments. Simultaneous push and pop, and clears presented while idle and while busy, separate the priority and stall rules from the data path.

// File: rtl/xf_pkg.sv
package xf_pkg;

  // next ring slot, wrapping at n slots
  function automatic int unsigned ring_step(int unsigned idx, int unsigned n);
    return (idx + 1 >= n) ? 0 : idx + 1;
  endfunction

  // empty slots that may still be pushed; one slot always stays unused
  function automatic int unsigned slots_free(int unsigned w, int unsigned r, int unsigned n);
    if (w < r) return r - w - 1;
    return n - w + r - 1;
  endfunction

  function automatic int unsigned slots_used(int unsigned w, int unsigned r, int unsigned n);
    return n - slots_free(w, r, n) - 1;
  endfunction

  // bytes of external memory the queue may touch
  function automatic int unsigned region_bytes(int unsigned d, int unsigned p);
    return ((d + p - 1) / p + 1) * p;
  endfunction

endpackage

// File: rtl/xf_wr_side.sv
module xf_wr_side #(
  parameter int DEPTH = 20,
  parameter int PAGE  = 8,
  parameter int IW    = 5,
  parameter int GW    = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr_fire,
  input  logic                 push_fire,
  input  logic [7:0]           push_byte,
  input  logic [IW-1:0]        rd_idx,
  output logic [IW-1:0]        wr_idx,
  output logic [GW-1:0]        wr_pg,
  output logic [PAGE*8-1:0]    stage_flat,
  output logic [PAGE*8-1:0]    stage_upd_flat,
  output logic                 full,
  output logic                 flush_evt
);
  import xf_pkg::*;
  localparam int N  = DEPTH + 1;
  localparam int OW = $clog2(PAGE);

  logic [7:0]    stage [PAGE];
  logic [OW-1:0] wr_off, nxt_off;
  logic [IW-1:0] nxt_idx;

  always_comb begin
    nxt_idx = IW'(ring_step(int'(wr_idx), N));
    if (nxt_idx == '0)               nxt_off = '0;
    else if (int'(wr_off) == PAGE-1) nxt_off = '0;
    else                             nxt_off = wr_off + 1'b1;
  end

  assign full      = (nxt_idx == rd_idx);
  assign flush_evt = push_fire && (nxt_off == '0);

  for (genvar i = 0; i < PAGE; i++) begin : g_pack
    assign stage_flat[i*8 +: 8]     = stage[i];
    assign stage_upd_flat[i*8 +: 8] = (push_fire && int'(wr_off) == i) ? push_byte : stage[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr_fire) begin
      wr_idx <= '0;
      wr_off <= '0;
      wr_pg  <= '0;
    end else if (push_fire) begin
      wr_idx <= nxt_idx;
      wr_off <= nxt_off;
      if (flush_evt) wr_pg <= (nxt_idx == '0) ? '0 : wr_pg + GW'(PAGE);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < PAGE; i++) stage[i] <= '0;
    end else if (push_fire) begin
      stage[wr_off] <= push_byte;
    end
  end

  // R1
  wr_ahead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_fire |=> (wr_idx != rd_idx));

  // R3
  flush_at_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_evt |=> ((wr_idx == '0) || (int'(wr_idx) % PAGE == 0)));

endmodule

// File: rtl/xf_rd_side.sv
module xf_rd_side #(
  parameter int DEPTH = 20,
  parameter int PAGE  = 8,
  parameter int IW    = 5,
  parameter int GW    = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_fire,
  input  logic              pop_fire,
  input  logic [IW-1:0]     wr_idx,
  input  logic [GW-1:0]     wr_pg,
  input  logic [PAGE*8-1:0] stage_flat,
  input  logic              copy_evt,
  input  logic [PAGE*8-1:0] copy_data,
  input  logic              fill_evt,
  input  logic [PAGE*8-1:0] fill_data,
  output logic [IW-1:0]     rd_idx,
  output logic [GW-1:0]     rd_pg,
  output logic [GW-1:0]     fetch_pg,
  output logic              fetch_evt,
  output logic [7:0]        pop_byte,
  output logic              empty
);
  import xf_pkg::*;
  localparam int N  = DEPTH + 1;
  localparam int OW = $clog2(PAGE);

  logic [7:0]    pf [PAGE];
  logic [OW-1:0] rd_off, nxt_off;
  logic [IW-1:0] nxt_idx;
  logic          use_pf;

  always_comb begin
    nxt_idx = IW'(ring_step(int'(rd_idx), N));
    if (nxt_idx == '0)               nxt_off = '0;
    else if (int'(rd_off) == PAGE-1) nxt_off = '0;
    else                             nxt_off = rd_off + 1'b1;
  end

  assign empty     = (rd_idx == wr_idx);
  assign fetch_evt = pop_fire && (nxt_off == '0);
  assign fetch_pg  = (nxt_idx == '0) ? '0 : rd_pg + GW'(PAGE);
  assign use_pf    = (rd_pg != wr_pg) || (wr_idx < rd_idx);
  assign pop_byte  = use_pf ? pf[rd_off] : stage_flat[rd_off*8 +: 8];

  always_ff @(posedge clk) begin
    if (!rst_n || clr_fire) begin
      rd_idx <= '0;
      rd_off <= '0;
      rd_pg  <= '0;
    end else if (pop_fire) begin
      rd_idx <= nxt_idx;
      rd_off <= nxt_off;
      if (fetch_evt) rd_pg <= fetch_pg;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < PAGE; i++) pf[i] <= '0;
    end else if (fill_evt) begin
      for (int i = 0; i < PAGE; i++) pf[i] <= fill_data[i*8 +: 8];
    end else if (copy_evt) begin
      for (int i = 0; i < PAGE; i++) pf[i] <= copy_data[i*8 +: 8];
    end
  end

  // R4
  fetch_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_evt |=> (int'(rd_pg) == int'(rd_idx)));

  // R1
  pop_not_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_fire |-> !empty);

endmodule

// File: rtl/xf_mem_port.sv
module xf_mem_port #(
  parameter int PAGE      = 8,
  parameter int AW        = 16,
  parameter int GW        = 5,
  parameter int BASE_ADDR = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_fire,
  input  logic              flush_evt,
  input  logic [GW-1:0]     flush_pg,
  input  logic [PAGE*8-1:0] flush_data,
  input  logic              fetch_evt,
  input  logic [GW-1:0]     fetch_pg,
  input  logic              mem_ack,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [PAGE*8-1:0] mem_wdata,
  output logic              fill_evt
);
  localparam logic [AW-1:0] BASE = AW'(BASE_ADDR);

  assign fill_evt = mem_req && !mem_we && mem_ack;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_req   <= 1'b1;
      mem_we    <= 1'b0;
      mem_addr  <= BASE;
      mem_wdata <= '0;
    end else if (clr_fire) begin
      mem_req  <= 1'b1;
      mem_we   <= 1'b0;
      mem_addr <= BASE;
    end else if (flush_evt) begin
      mem_req   <= 1'b1;
      mem_we    <= 1'b1;
      mem_addr  <= BASE + AW'(flush_pg);
      mem_wdata <= flush_data;
    end else if (fetch_evt) begin
      mem_req  <= 1'b1;
      mem_we   <= 1'b0;
      mem_addr <= BASE + AW'(fetch_pg);
    end else if (mem_req && mem_ack) begin
      mem_req <= 1'b0;
    end
  end

  // R6
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr)));

  // R6
  req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack) |=> !mem_req);

endmodule

// File: rtl/ext_ram_fifo.sv
module ext_ram_fifo #(
  parameter int DEPTH     = 20,
  parameter int PAGE      = 8,
  parameter int AW        = 16,
  parameter int BASE_ADDR = 256,
  localparam int CW       = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              push_valid,
  input  logic [7:0]        push_data,
  output logic              push_ready,
  input  logic              pop_valid,
  output logic [7:0]        pop_data,
  output logic              pop_ready,
  output logic              full,
  output logic              empty,
  output logic [CW-1:0]     free_cnt,
  output logic [CW-1:0]     used_cnt,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [PAGE*8-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [PAGE*8-1:0] mem_rdata
);
  import xf_pkg::*;
  localparam int N      = DEPTH + 1;
  localparam int IW     = $clog2(N);
  localparam int REGION = region_bytes(DEPTH, PAGE);
  localparam int GW     = $clog2(REGION);

  logic              busy, clr_fire, push_fire, pop_fire;
  logic              flush_evt, fetch_evt, fill_evt, copy_evt;
  logic [IW-1:0]     wr_idx, rd_idx;
  logic [GW-1:0]     wr_pg, rd_pg, fetch_pg;
  logic [PAGE*8-1:0] stage_flat, stage_upd_flat;

  assign busy       = mem_req;
  assign clr_fire   = clr && !busy;
  assign pop_ready  = !busy && !empty && !clr;
  assign push_ready = !busy && !full && !clr && !(pop_valid && !empty);
  assign pop_fire   = pop_valid && pop_ready;
  assign push_fire  = push_valid && push_ready;
  assign copy_evt   = flush_evt && (wr_pg == rd_pg);

  assign free_cnt = CW'(slots_free(int'(wr_idx), int'(rd_idx), N));
  assign used_cnt = CW'(slots_used(int'(wr_idx), int'(rd_idx), N));

  xf_wr_side #(.DEPTH(DEPTH), .PAGE(PAGE), .IW(IW), .GW(GW)) u_wr (
    .clk(clk), .rst_n(rst_n), .clr_fire(clr_fire), .push_fire(push_fire),
    .push_byte(push_data), .rd_idx(rd_idx), .wr_idx(wr_idx), .wr_pg(wr_pg),
    .stage_flat(stage_flat), .stage_upd_flat(stage_upd_flat), .full(full),
    .flush_evt(flush_evt));

  xf_rd_side #(.DEPTH(DEPTH), .PAGE(PAGE), .IW(IW), .GW(GW)) u_rd (
    .clk(clk), .rst_n(rst_n), .clr_fire(clr_fire), .pop_fire(pop_fire),
    .wr_idx(wr_idx), .wr_pg(wr_pg), .stage_flat(stage_flat),
    .copy_evt(copy_evt), .copy_data(stage_upd_flat), .fill_evt(fill_evt),
    .fill_data(mem_rdata), .rd_idx(rd_idx), .rd_pg(rd_pg), .fetch_pg(fetch_pg),
    .fetch_evt(fetch_evt), .pop_byte(pop_data), .empty(empty));

  xf_mem_port #(.PAGE(PAGE), .AW(AW), .GW(GW), .BASE_ADDR(BASE_ADDR)) u_mem (
    .clk(clk), .rst_n(rst_n), .clr_fire(clr_fire), .flush_evt(flush_evt),
    .flush_pg(wr_pg), .flush_data(stage_upd_flat), .fetch_evt(fetch_evt),
    .fetch_pg(fetch_pg), .mem_ack(mem_ack), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .fill_evt(fill_evt));

  // R1
  push_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_fire |=> (int'(used_cnt) == int'($past(used_cnt)) + 1));

  // R1
  pop_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_fire |=> (int'(used_cnt) + 1 == int'($past(used_cnt))));

  // R7
  count_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(free_cnt) + int'(used_cnt)) == DEPTH);

  // R8
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_fire |=> (empty && mem_req && !mem_we && int'(mem_addr) == BASE_ADDR));

  // R10
  addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> ((int'(mem_addr) >= BASE_ADDR) && (int'(mem_addr) - BASE_ADDR < REGION)
                 && ((int'(mem_addr) - BASE_ADDR) % PAGE == 0)));

  // R3
  flush_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_evt |=> (mem_req && mem_we));

  // R6
  stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !(push_fire || pop_fire));

endmodule

// File: tb/test_ext_ram_fifo.sv
module test_ext_ram_fifo;
  localparam int DEPTH = 20, PAGE = 8, AW = 16, BASE = 256, LAT = 2;
  localparam int N = DEPTH + 1;
  localparam int REGION = ((DEPTH + PAGE - 1) / PAGE + 1) * PAGE;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 0, rst_n = 0, clr = 0, push_valid = 0, pop_valid = 0, mem_ack = 0;
  logic [7:0] push_data = 0, pop_data;
  logic push_ready, pop_ready, full, empty, mem_req, mem_we;
  logic [CW-1:0] free_cnt, used_cnt;
  logic [AW-1:0] mem_addr;
  logic [PAGE*8-1:0] mem_wdata, mem_rdata = '0;

  always #10 clk = ~clk;

  ext_ram_fifo #(.DEPTH(DEPTH), .PAGE(PAGE), .AW(AW), .BASE_ADDR(BASE)) i_ext_ram_fifo (
    .clk(clk), .rst_n(rst_n), .clr(clr), .push_valid(push_valid), .push_data(push_data),
    .push_ready(push_ready), .pop_valid(pop_valid), .pop_data(pop_data),
    .pop_ready(pop_ready), .full(full), .empty(empty), .free_cnt(free_cnt),
    .used_cnt(used_cnt), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata));

  // behavioural model
  logic [7:0] q[$];
  logic [7:0] mem [REGION];
  int w_slot, r_slot, lat, writes, tests, fails;
  bit busy_m, exp_we, seen;
  int exp_addr, held_addr;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  task automatic step(bit pv, bit qv, bit cv, logic [7:0] d);
    bit exp_push, exp_pop, was_busy;
    int off;
    @(negedge clk);
    push_valid = pv; pop_valid = qv; clr = cv; push_data = d;
    mem_ack = 0;
    if (mem_req) begin
      off = int'(mem_addr) - BASE;
      if (!seen) begin
        seen = 1; lat = 0; held_addr = int'(mem_addr);
        chk(busy_m, "R6", "unexpected request", 1, 0);
        chk(int'(mem_addr) == exp_addr, mem_we ? "R3" : "R4", "request address",
            int'(mem_addr), exp_addr);
        chk(mem_we == exp_we, mem_we ? "R3" : "R4", "request direction",
            int'(mem_we), int'(exp_we));
        chk(off >= 0 && off + PAGE <= REGION, "R10", "address in region", off, 0);
      end else begin
        chk(int'(mem_addr) == held_addr, "R6", "address held", int'(mem_addr), held_addr);
      end
      lat++;
      if (lat >= LAT && off >= 0 && off + PAGE <= REGION) begin
        mem_ack = 1;
        for (int i = 0; i < PAGE; i++) begin
          if (mem_we) mem[off + i] = mem_wdata[i*8 +: 8];
          else mem_rdata[i*8 +: 8] = mem[off + i];
        end
        if (mem_we) writes++;
      end
    end
    #1;
    exp_pop  = !busy_m && q.size() != 0 && !cv;
    exp_push = !busy_m && q.size() != DEPTH && !cv && !(qv && q.size() != 0);
    chk(pop_ready == exp_pop, "R6", "pop_ready", int'(pop_ready), int'(exp_pop));
    chk(push_ready == exp_push, "R9", "push_ready", int'(push_ready), int'(exp_push));
    chk(empty == (q.size() == 0), "R1", "empty", int'(empty), int'(q.size() == 0));
    chk(full == (q.size() == DEPTH), "R1", "full", int'(full), int'(q.size() == DEPTH));
    chk(int'(used_cnt) == q.size(), "R7", "used_cnt", int'(used_cnt), q.size());
    chk(int'(free_cnt) == DEPTH - q.size(), "R7", "free_cnt", int'(free_cnt), DEPTH - q.size());
    if (qv && exp_pop)
      chk(pop_data == q[0], "R2", "pop_data", int'(pop_data), int'(q[0]));
    was_busy = busy_m;
    if (mem_ack) begin busy_m = 0; seen = 0; end
    if (cv && !was_busy) begin
      q.delete(); w_slot = 0; r_slot = 0;
      busy_m = 1; exp_we = 0; exp_addr = BASE;
    end else if (qv && exp_pop) begin
      void'(q.pop_front());
      r_slot = (r_slot + 1) % N;
      if (r_slot % PAGE == 0) begin busy_m = 1; exp_we = 0; exp_addr = BASE + r_slot; end
    end else if (pv && exp_push) begin
      q.push_back(d);
      if ((w_slot + 1) % N % PAGE == 0) begin
        busy_m = 1; exp_we = 1; exp_addr = BASE + (w_slot / PAGE) * PAGE;
      end
      w_slot = (w_slot + 1) % N;
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    summary();
  end

  initial begin
    int wr0;
    logic [7:0] seq;
    for (int i = 0; i < REGION; i++) mem[i] = 8'hEE;
    repeat (3) @(negedge clk);
    #1;
    chk(empty == 1'b1, "R1", "reset empty", int'(empty), 1);
    chk(int'(used_cnt) == 0, "R1", "reset used", int'(used_cnt), 0);
    chk(mem_req && !mem_we && int'(mem_addr) == BASE, "R8", "reset prefetch", int'(mem_addr), BASE);
    busy_m = 1; exp_we = 0; exp_addr = BASE; seen = 0;
    @(negedge clk); rst_n = 1;
    idle(4);

    // bypass within one page: no write request
    wr0 = writes;
    for (int i = 0; i < 3; i++) step(1, 0, 0, 8'h10 + 8'(i));
    for (int i = 0; i < 3; i++) step(0, 1, 0, 8'h00);
    chk(writes == wr0, "R5", "writes during bypass", writes, wr0);

    // fill past full, then drain past empty
    seq = 8'h40;
    for (int i = 0; i < 40; i++) begin step(1, 0, 0, seq); seq++; end
    chk(q.size() == DEPTH, "R1", "stored at full", q.size(), DEPTH);
    step(1, 1, 0, 8'hAA);
    for (int i = 0; i < 40; i++) step(0, 1, 0, 8'h00);
    chk(q.size() == 0, "R1", "stored after drain", q.size(), 0);

    // mixed traffic at several ratios
    for (int ph = 0; ph < 4; ph++) begin
      int pp, qp;
      pp = (ph == 0) ? 50 : (ph == 1) ? 80 : (ph == 2) ? 30 : 95;
      qp = (ph == 3) ? 60 : 100 - pp;
      for (int i = 0; i < 1500; i++) begin
        step($urandom_range(99) < pp, $urandom_range(99) < qp, 0, seq);
        seq++;
      end
    end

    // clear while idle and clear while busy
    idle(6);
    for (int i = 0; i < 5; i++) begin step(1, 0, 0, seq); seq++; end
    idle(6);
    step(0, 0, 1, 8'h00);
    chk(q.size() == 0 && busy_m, "R8", "clear accepted", q.size(), 0);
    idle(6);
    for (int i = 0; i < PAGE; i++) begin step(1, 0, 0, seq); seq++; end
    step(0, 0, 1, 8'h00);
    chk(q.size() == PAGE, "R8", "clear ignored while busy", q.size(), PAGE);
    idle(6);
    for (int i = 0; i < 3 * PAGE; i++) step(0, 1, 0, 8'h00);
    idle(4);
    summary();
  end
endmodule